// File: doc/BRIEF.md
# Gated 16-bit Up-Counter with Prescaler

This block is a 16-bit up-counter for a peripheral timer slice. A single-cycle count-tick input stands in for whatever clock source the surrounding logic has chosen. That tick stream first passes through a divider that can be set to 1, 2, 4 or 8. The divided pulse then advances the counter, but only while a count-enable gate allows it.

The gate can come from one of four places: an external pin that is synchronised on entry, the wrap pulse of an 8-bit companion timer, the period-match pulse of a second timer, or a watchdog time-out pulse. A polarity control chooses whether a high or a low gate level enables counting. When gating is switched off, the counter runs freely.

Software reaches the counter through two byte lanes, low and high, which can be read and written independently. Writing either byte also empties the hidden divider. When the counter wraps from all ones to zero, a sticky overflow flag is set, and it stays set until a clear strobe removes it.

Top module: `gated_timer16`

## Requirements
- R1: After reset, both counter bytes read 00h and the overflow flag is 0.
- R2: Prescale select code 0, 1, 2 or 3 gives one counter increment per 1, 2, 4 or 8 accepted ticks. Cycles with no tick never change the counter.
- R3: A write to the low byte or the high byte empties the divider. After the write, a full 2^code ticks are needed before the next increment.
- R4: With gate enable at 0, the counter advances on every divided pulse, whatever the gate sources and the polarity are.
- R5: With gate enable at 1, polarity 0 allows counting while the selected gate is low, and polarity 1 allows it while the gate is high. In all other cases the counter holds its value.
- R6: Gate source code 0 selects the external pin, which takes effect two clocks after it changes. Code 1 selects the companion-timer wrap pulse, code 2 the period-match pulse and code 3 the watchdog time-out pulse. Unselected sources have no effect.
- R7: An increment from FFFFh to 0000h sets the overflow flag in the same clock edge.
- R8: The flag stays set until the clear strobe is 1. If an overflow occurs in the same cycle as a clear, the flag remains set.
- R9: A byte write loads that byte from the write data, leaves the other byte unchanged, and takes precedence over an increment in the same cycle.
- R10: Outside of writes, the counter changes by at most +1 per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-tick from the selected clock source |
| pre_sel_i | input | 2 | Prescale code (divide by 2^code) |
| gate_en_i | input | 1 | 1 = counting gated, 0 = free run |
| gate_pol_i | input | 1 | 1 = gate active high, 0 = active low |
| gate_src_i | input | 2 | Gate source code |
| gate_pin_i | input | 1 | Asynchronous external gate pin |
| t0_wrap_i | input | 1 | Companion 8-bit timer wrap pulse |
| t2_match_i | input | 1 | Second timer period-match pulse |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| wr_lo_i | input | 1 | Write strobe, low byte |
| wr_hi_i | input | 1 | Write strobe, high byte |
| wdata_i | input | 8 | Write data |
| cnt_lo_o | output | 8 | Counter low byte |
| cnt_hi_o | output | 8 | Counter high byte |
| flag_clr_i | input | 1 | Overflow flag clear strobe |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default parameters: a 16-bit counter in two 8-bit lanes, a 2-bit prescale code and a two-stage pin synchroniser. With these defaults, every prescale ratio can be reached within eight ticks, and the wrap from FFFFh is reached by preloading FFFEh through the byte lanes rather than by counting 65536 steps. The two-cycle pin latency is short enough that the bench can wait it out between gate patterns and still check all four polarity combinations.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
   typedef enum logic [1:0] {
      GSRC_PIN   = 2'd0,
      GSRC_WRAP  = 2'd1,
      GSRC_MATCH = 2'd2,
      GSRC_WDT   = 2'd3
   } gate_src_e;
endpackage

// File: rtl/gtmr_prescaler.sv
module gtmr_prescaler #(
   parameter int SEL_W = 2,
   localparam int PCNT_W = (1 << SEL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             clr_i,
   output logic             pulse_o
);
   logic [PCNT_W-1:0] pcnt;
   logic [PCNT_W-1:0] last;

   always_comb begin
      last    = PCNT_W'((1 << sel_i) - 1);
      pulse_o = tick_i && !clr_i && (pcnt == last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pcnt <= '0;
      else if (clr_i)   pcnt <= '0;
      else if (pulse_o) pcnt <= '0;
      else if (tick_i)  pcnt <= pcnt + 1'b1;
   end
endmodule

// File: rtl/gtmr_gate.sv
module gtmr_gate
   import gtmr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      en_i,
   input  logic      pol_i,
   input  gate_src_e src_i,
   input  logic      pin_i,
   input  logic      wrap_i,
   input  logic      match_i,
   input  logic      wdt_i,
   output logic      allow_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   gate_lvl;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else if (s == 0) sync_q[s] <= pin_i;
            else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   always_comb begin
      unique case (src_i)
         GSRC_PIN:   gate_lvl = sync_q[SYNC_STAGES-1];
         GSRC_WRAP:  gate_lvl = wrap_i;
         GSRC_MATCH: gate_lvl = match_i;
         default:    gate_lvl = wdt_i;
      endcase
      allow_o = !en_i || (gate_lvl == pol_i);
   end
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 2,
   localparam int CNT_W = BYTE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_i,
   input  logic [LANES-1:0]  wr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic              clr_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              flag_o
);
   logic wrap;

   assign wrap = inc_i && !(|wr_i) && (&cnt_o);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt_o[l*BYTE_W +: BYTE_W] <= '0;
            else if (wr_i[l])   cnt_o[l*BYTE_W +: BYTE_W] <= wdata_i;
            else if (|wr_i)     cnt_o[l*BYTE_W +: BYTE_W] <= cnt_o[l*BYTE_W +: BYTE_W];
            else if (inc_i)     cnt_o[l*BYTE_W +: BYTE_W] <= BYTE_W'((cnt_o + 1'b1) >> (l*BYTE_W));
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (wrap)  flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
   import gtmr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int CNT_W       = 16,
   parameter int SEL_W       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int LANES      = CNT_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [SEL_W-1:0]  pre_sel_i,
   input  logic              gate_en_i,
   input  logic              gate_pol_i,
   input  logic [1:0]        gate_src_i,
   input  logic              gate_pin_i,
   input  logic              t0_wrap_i,
   input  logic              t2_match_i,
   input  logic              wdt_to_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] cnt_lo_o,
   output logic [BYTE_W-1:0] cnt_hi_o,
   input  logic              flag_clr_i,
   output logic              ovf_flag_o
);
   generate
      if (LANES != 2)       begin : g_bad_lanes $error("CNT_W must be twice BYTE_W"); end
      if (SEL_W < 1)        begin : g_bad_sel   $error("SEL_W must be at least 1"); end
      if (SYNC_STAGES < 2)  begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic             pre_pulse;
   logic             allow;
   logic [LANES-1:0] wr_lane;
   logic [CNT_W-1:0] cnt;

   assign wr_lane = {wr_hi_i, wr_lo_i};

   gtmr_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sel_i(pre_sel_i),
      .clr_i(|wr_lane), .pulse_o(pre_pulse)
   );

   gtmr_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk(clk), .rst_n(rst_n), .en_i(gate_en_i), .pol_i(gate_pol_i),
      .src_i(gate_src_e'(gate_src_i)), .pin_i(gate_pin_i), .wrap_i(t0_wrap_i),
      .match_i(t2_match_i), .wdt_i(wdt_to_i), .allow_o(allow)
   );

   gtmr_counter #(.BYTE_W(BYTE_W), .LANES(LANES)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(pre_pulse && allow), .wr_i(wr_lane),
      .wdata_i(wdata_i), .clr_i(flag_clr_i), .cnt_o(cnt), .flag_o(ovf_flag_o)
   );

   assign cnt_lo_o = cnt[BYTE_W-1:0];
   assign cnt_hi_o = cnt[CNT_W-1:BYTE_W];
endmodule

// File: rtl/gated_timer16_chk.sv
module gated_timer16_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              gate_en_i,
   input logic              gate_pol_i,
   input logic [1:0]        gate_src_i,
   input logic              t0_wrap_i,
   input logic              wr_lo_i,
   input logic              wr_hi_i,
   input logic [BYTE_W-1:0] wdata_i,
   input logic [BYTE_W-1:0] cnt_lo_o,
   input logic [BYTE_W-1:0] cnt_hi_o,
   input logic              flag_clr_i,
   input logic              ovf_flag_o
);
   logic [2*BYTE_W-1:0] cnt;
   logic                nowr;
   assign cnt  = {cnt_hi_o, cnt_lo_o};
   assign nowr = !wr_lo_i && !wr_hi_i;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      nowr |=> (cnt == $past(cnt)) || (cnt == (2*BYTE_W)'($past(cnt) + 1'b1))); // R10
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (nowr && !tick_i) |=> $stable(cnt)); // R2
   AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo_i |=> cnt_lo_o == $past(wdata_i)); // R9
   AST_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_i && !wr_hi_i) |=> cnt_hi_o == $past(cnt_hi_o)); // R9
   AST_FLAG_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag_o) |-> ($past(cnt) == '1 && cnt == '0)); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag_o && !flag_clr_i) |=> ovf_flag_o); // R8
   AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (nowr && gate_en_i && gate_pol_i && gate_src_i == 2'd1 && !t0_wrap_i) |=> $stable(cnt)); // R5
endmodule

bind gated_timer16 gated_timer16_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_en_i(gate_en_i),
   .gate_pol_i(gate_pol_i), .gate_src_i(gate_src_i), .t0_wrap_i(t0_wrap_i),
   .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .wdata_i(wdata_i), .cnt_lo_o(cnt_lo_o),
   .cnt_hi_o(cnt_hi_o), .flag_clr_i(flag_clr_i), .ovf_flag_o(ovf_flag_o)
);

// File: tb/sim_gated_timer16.sv
module sim_gated_timer16;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 0, gate_en_i = 0, gate_pol_i = 0, gate_pin_i = 0;
   logic [1:0] pre_sel_i = 0, gate_src_i = 0;
   logic       t0_wrap_i = 0, t2_match_i = 0, wdt_to_i = 0;
   logic       wr_lo_i = 0, wr_hi_i = 0, flag_clr_i = 0;
   logic [7:0] wdata_i = 0;
   logic [7:0] cnt_lo_o, cnt_hi_o;
   logic       ovf_flag_o;
   int         n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   gated_timer16 u0 (.*);

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int cnt_now();
      return {cnt_hi_o, cnt_lo_o};
   endfunction

   task automatic run_ticks(int n);
      tick_i = 1;
      repeat (n) @(negedge clk);
      tick_i = 0;
   endtask

   task automatic load(int v);
      wr_lo_i = 1; wr_hi_i = 1; wdata_i = v[7:0];
      wr_hi_i = 0;
      @(negedge clk);
      wr_lo_i = 0; wr_hi_i = 1; wdata_i = v[15:8];
      @(negedge clk);
      wr_hi_i = 0;
   endtask

   task automatic t_reset();
      check("R1 cnt", cnt_now(), 0);
      check("R1 flag", ovf_flag_o, 0);
   endtask

   task automatic t_prescale();
      for (int s = 0; s < 4; s++) begin
         pre_sel_i = 2'(s);
         load(0);
         run_ticks(8);
         check($sformatf("R2 ratio code %0d", s), cnt_now(), 8 >> s);
         repeat (3) @(negedge clk);
         check("R2 idle hold", cnt_now(), 8 >> s);
      end
   endtask

   task automatic t_pre_clear();
      pre_sel_i = 3;
      load(16'h0010);
      run_ticks(5);
      load(16'h0010);
      run_ticks(7);
      check("R3 after 7", cnt_now(), 16'h0010);
      run_ticks(1);
      check("R3 after 8", cnt_now(), 16'h0011);
   endtask

   task automatic t_free_run();
      pre_sel_i = 0; gate_en_i = 0; gate_pol_i = 1; gate_src_i = 1;
      load(16'h0100);
      run_ticks(5);
      check("R4 free run", cnt_now(), 16'h0105);
   endtask

   task automatic t_polarity();
      pre_sel_i = 0; gate_en_i = 1; gate_src_i = 0;
      for (int c = 0; c < 4; c++) begin
         int base;
         gate_pin_i = c[0]; gate_pol_i = c[1];
         repeat (3) @(negedge clk);
         base = cnt_now();
         run_ticks(4);
         check($sformatf("R5 pin=%0d pol=%0d", c[0], c[1]), cnt_now(),
               base + ((c[0] == c[1]) ? 4 : 0));
      end
      gate_pin_i = 0; gate_pol_i = 1;
      repeat (3) @(negedge clk);
      gate_pin_i = 1;
      tick_i = 1;
      @(negedge clk);
      @(negedge clk);
      tick_i = 0;
      begin
         int b = cnt_now();
         run_ticks(1);
         check("R6 pin sync latency", cnt_now(), b + 1);
      end
      gate_pin_i = 0;
   endtask

   task automatic t_sources();
      pre_sel_i = 0; gate_en_i = 1; gate_pol_i = 1;
      for (int src = 1; src < 4; src++) begin
         int base = cnt_now();
         gate_src_i = 2'(src);
         tick_i = 1;
         for (int i = 0; i < 6; i++) begin
            logic hit = (i == 1) || (i == 4);
            t0_wrap_i  = (src == 1) ? hit : !hit;
            t2_match_i = (src == 2) ? hit : !hit;
            wdt_to_i   = (src == 3) ? hit : !hit;
            @(negedge clk);
         end
         tick_i = 0; t0_wrap_i = 0; t2_match_i = 0; wdt_to_i = 0;
         check($sformatf("R6 source %0d", src), cnt_now(), base + 2);
      end
      gate_en_i = 0;
   endtask

   task automatic t_overflow();
      pre_sel_i = 0; gate_en_i = 0;
      load(16'hFFFE);
      run_ticks(1);
      check("R7 at FFFF", cnt_now(), 16'hFFFF);
      check("R7 flag before wrap", ovf_flag_o, 0);
      run_ticks(1);
      check("R7 wrapped", cnt_now(), 0);
      check("R7 flag set", ovf_flag_o, 1);
      run_ticks(3);
      check("R8 sticky", ovf_flag_o, 1);
      flag_clr_i = 1; @(negedge clk); flag_clr_i = 0;
      check("R8 cleared", ovf_flag_o, 0);
      load(16'hFFFF);
      tick_i = 1; flag_clr_i = 1; @(negedge clk); tick_i = 0; flag_clr_i = 0;
      check("R8 wrap beats clear", ovf_flag_o, 1);
      flag_clr_i = 1; @(negedge clk); flag_clr_i = 0;
   endtask

   task automatic t_write_override();
      pre_sel_i = 0; gate_en_i = 0;
      load(16'h1234);
      tick_i = 1; wr_lo_i = 1; wdata_i = 8'h80;
      @(negedge clk);
      wr_lo_i = 0;
      check("R9 low write wins", cnt_now(), 16'h1280);
      wr_hi_i = 1; wdata_i = 8'hAB;
      @(negedge clk);
      wr_hi_i = 0; tick_i = 0;
      check("R9 high write keeps low", cnt_now(), 16'hAB80);
      run_ticks(2);
      check("R10 one per clock", cnt_now(), 16'hAB82);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_prescale();
      t_pre_clear();
      t_free_run();
      t_polarity();
      t_sources();
      t_overflow();
      t_write_override();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule